// File: doc/BRIEF.md
# Bit Slip Realignment Buffer

This block follows an oversampling phase picker. Each cycle the picker hands over one recovered word and a code that says how many bits of it are real. Normally that is a full byte. When the selected sample position wraps around, because of heavy jitter or a small frequency offset between transmitter and receiver, a cycle instead carries one bit fewer (underflow) or one bit more (overflow). The block repacks this uneven bit stream into aligned bytes with a valid strobe, so that the logic downstream sees an unbroken byte stream.

Small slips are taken up by a bit buffer. A signed slip counter tracks the net bit offset, and the bit buffer holds 8 plus that offset bits. When eight slips of the same sign have built up, the counter returns to zero and the surplus or missing byte is handled by a small byte FIFO:

- **Surplus:** a whole extra byte is stored in the FIFO.
- **Deficit:** a stored byte is drained from the FIFO. If the FIFO is empty, there is a one-cycle gap in the output.

Status pulses report when the FIFO cannot absorb a further slip.

After reset the bit buffer is preloaded with one byte of zero bits. This centres the slip range, so the output stream lags the input by exactly one byte.

Top module: `bitslip_realign`

## Requirements
- R1: While reset is held and after it is released, before any accepted input, `out_valid`, `ovf_err` and `unf_err` are 0 and `out_byte` is 0.
- R2: Bits are taken least significant first. With `in_code` = 2'b00, the eight bits `in_bits[7:0]` are appended to the stream. The output stream is one zero byte followed by the input bits, cut into bytes with the earliest bit in bit 0. Each output appears on the clock edge that samples the input.
- R3: With `in_code` = 2'b01 (underflow), only `in_bits[7:1]` are appended. `in_bits[0]` is the later duplicate sample and is discarded.
- R4: With `in_code` = 2'b10 (overflow), all nine bits `in_bits[8:0]` are appended.
- R5: `in_code` = 2'b11 is handled exactly like 2'b00. `in_bits[8]` is ignored for every code except 2'b10.
- R6: A cycle with `in_valid` low appends nothing. On the next edge it gives `out_valid`, `ovf_err` and `unf_err` low and changes no state.
- R7: A net surplus of eight bits places one whole byte in the byte FIFO. That byte is delivered later in stream order, with no loss while the FIFO holds fewer than `FIFO_DEPTH` bytes.
- R8: When the net deficit reaches eight bits and the FIFO is empty, that cycle gives `out_valid` low and `unf_err` high. The byte stream then continues without a gap in content.
- R9: When the net deficit reaches eight bits and the FIFO is not empty, `out_valid` stays high and the oldest stored byte is delivered.
- R10: A surplus byte that arrives while the FIFO holds `FIFO_DEPTH` bytes raises `ovf_err` for that cycle, with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input word is present this cycle |
| in_bits | input | BYTE_W+1 | Recovered bits, earliest in bit 0 |
| in_code | input | 2 | Bit-count code: 00 eight, 01 seven, 10 nine, 11 eight |
| out_byte | output | BYTE_W | Aligned output byte, earliest bit in bit 0 |
| out_valid | output | 1 | `out_byte` holds a new byte |
| ovf_err | output | 1 | A surplus byte was dropped because the FIFO was full |
| unf_err | output | 1 | A deficit found the FIFO empty, so no byte was produced |

## Verification
Every result is registered once. The byte, valid strobe and both status pulses for an input sampled on edge k are all visible after edge k. The bench drives each word at the falling edge, waits for the next rising edge, and samples 1 ns later, so each check reads exactly the response to that word.

A bit-queue model in the bench predicts both the byte content and the bubble cycles. It emits a byte whenever more than eight bits would otherwise stay queued. It predicts overflow when more than `8*FIFO_DEPTH + 15` bits remain. Gaps and FIFO-supplied bytes are therefore checked in the exact cycle where the slip count crosses a byte.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    SLIP_NONE  = 2'b00,
    SLIP_SHORT = 2'b01,
    SLIP_LONG  = 2'b10,
    SLIP_RSVD  = 2'b11
  } slip_code_e;

  // How many whole bytes the bit buffer releases in one accepted cycle
  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_ONE  = 2'b01,
    PK_TWO  = 2'b10
  } pk_kind_e;

  // Net change of the bit offset caused by one input word
  function automatic int slip_delta(input slip_code_e c);
    case (c)
      SLIP_SHORT: return -1;
      SLIP_LONG:  return 1;
      default:    return 0;
    endcase
  endfunction

  // Bits held in the bit buffer for a given signed offset
  function automatic int held_bits(input int offset, input int w);
    return w + offset;
  endfunction

endpackage

// File: rtl/bsr_bit_packer.sv
module bsr_bit_packer
  import bsr_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = $clog2(W) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W:0]           in_bits,
  input  slip_code_e           in_code,
  output pk_kind_e             kind,
  output logic [W-1:0]         byte0,
  output logic [W-1:0]         byte1,
  output logic signed [SW-1:0] slip
);

  logic [2*W-1:0]       buf_q, buf_d;
  logic signed [SW-1:0] slip_q, slip_d;
  logic [W:0]           fresh;
  logic [3*W-1:0]       merged;
  int                   occ;
  int                   tally;

  // Align the valid bits of the word to bit 0; a short word loses its
  // first sample, which duplicates the last bit of the previous word
  always_comb begin
    unique case (in_code)
      SLIP_SHORT: fresh = {2'b00, in_bits[W-1:1]};
      SLIP_LONG:  fresh = in_bits;
      default:    fresh = {1'b0, in_bits[W-1:0]};
    endcase
  end

  always_comb begin
    occ    = held_bits(int'(slip_q), W);
    merged = {{W{1'b0}}, buf_q} | ({{(2*W-1){1'b0}}, fresh} << occ);
    tally  = int'(slip_q) + slip_delta(in_code);
    kind   = PK_ONE;
    byte0  = merged[W-1:0];
    byte1  = merged[2*W-1:W];
    buf_d  = merged[3*W-1:W];
    slip_d = SW'(tally);
    if (tally == W) begin
      kind   = PK_TWO;
      buf_d  = {{W{1'b0}}, merged[3*W-1:2*W]};
      slip_d = '0;
    end else if (tally == -W) begin
      kind   = PK_NONE;
      buf_d  = merged[2*W-1:0];
      slip_d = '0;
    end
    if (!in_valid) begin
      kind   = PK_NONE;
      buf_d  = buf_q;
      slip_d = slip_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      slip_q <= '0;
    end else begin
      buf_q  <= buf_d;
      slip_q <= slip_d;
    end
  end

  assign slip = slip_q;

endmodule

// File: rtl/bsr_byte_fifo.sv
module bsr_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [1:0]    push_cnt,
  input  logic [W-1:0]  din0,
  input  logic [W-1:0]  din1,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level
);

  logic [DEPTH*W-1:0] ent_q, ent_d, shifted;
  logic [LW-1:0]      level_q;
  int                 base;

  always_comb begin
    shifted = pop ? (ent_q >> W) : ent_q;
    base    = int'(level_q) - (pop ? 1 : 0);
  end

  // Each entry takes the shifted contents or one of the two new bytes
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      if (push_cnt != 2'd0 && i == base)
        ent_d[i*W +: W] = din0;
      else if (push_cnt == 2'd2 && i == base + 1)
        ent_d[i*W +: W] = din1;
      else
        ent_d[i*W +: W] = shifted[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q   <= '0;
      level_q <= '0;
    end else begin
      ent_q   <= ent_d;
      level_q <= LW'(base + int'(push_cnt));
    end
  end

  assign head  = ent_q[W-1:0];
  assign level = level_q;

endmodule

// File: rtl/bitslip_realign.sv
module bitslip_realign
  import bsr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int SW = $clog2(BYTE_W) + 2,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W:0]   in_bits,
  input  logic [1:0]        in_code,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              ovf_err,
  output logic              unf_err
);

  pk_kind_e             kind;
  logic [BYTE_W-1:0]    pk_b0, pk_b1, fifo_head;
  logic signed [SW-1:0] slip_now;
  logic [LW-1:0]        fifo_level;
  logic                 fifo_pop;
  logic [1:0]           fifo_push;
  logic [BYTE_W-1:0]    fifo_d0, fifo_d1;
  logic                 fifo_empty, fifo_full;
  // Named events for the checker
  logic                 surplus_evt, deficit_evt, drop_evt, bubble_evt;
  logic [BYTE_W-1:0]    nxt_byte;
  logic                 nxt_valid;

  bsr_bit_packer #(.W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bits  (in_bits),
    .in_code  (slip_code_e'(in_code)),
    .kind     (kind),
    .byte0    (pk_b0),
    .byte1    (pk_b1),
    .slip     (slip_now)
  );

  bsr_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (fifo_pop),
    .push_cnt (fifo_push),
    .din0     (fifo_d0),
    .din1     (fifo_d1),
    .head     (fifo_head),
    .level    (fifo_level)
  );

  assign fifo_empty  = (fifo_level == '0);
  assign fifo_full   = (int'(fifo_level) == FIFO_DEPTH);
  assign surplus_evt = in_valid && (kind == PK_TWO);
  assign deficit_evt = in_valid && (kind == PK_NONE);

  // Older bytes sit in the FIFO, so it always feeds the output first
  always_comb begin
    fifo_pop   = 1'b0;
    fifo_push  = 2'd0;
    fifo_d0    = pk_b0;
    fifo_d1    = pk_b1;
    nxt_byte   = pk_b0;
    nxt_valid  = 1'b0;
    drop_evt   = 1'b0;
    bubble_evt = 1'b0;
    if (in_valid) begin
      unique case (kind)
        PK_ONE: begin
          nxt_valid = 1'b1;
          if (!fifo_empty) begin
            nxt_byte  = fifo_head;
            fifo_pop  = 1'b1;
            fifo_push = 2'd1;
          end
        end
        PK_TWO: begin
          nxt_valid = 1'b1;
          if (fifo_empty) begin
            fifo_push = 2'd1;
            fifo_d0   = pk_b1;
          end else begin
            nxt_byte  = fifo_head;
            fifo_pop  = 1'b1;
            if (fifo_full) begin
              fifo_push = 2'd1;
              drop_evt  = 1'b1;
            end else begin
              fifo_push = 2'd2;
            end
          end
        end
        default: begin
          if (fifo_empty) begin
            bubble_evt = 1'b1;
          end else begin
            nxt_valid = 1'b1;
            nxt_byte  = fifo_head;
            fifo_pop  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
      ovf_err   <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
      ovf_err   <= drop_evt;
      unf_err   <= bubble_evt;
      if (nxt_valid) out_byte <= nxt_byte;
    end
  end

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int SW   = $clog2(W) + 2,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 ovf_err,
  input logic                 unf_err,
  input logic                 surplus_evt,
  input logic                 deficit_evt,
  input logic signed [SW-1:0] slip,
  input logic [LW-1:0]        fifo_level
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !ovf_err && !unf_err)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(slip) && $stable(fifo_level))); // R6

  AST_BUBBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid != unf_err)); // R8

  AST_OVF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> out_valid); // R10

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= DEPTH); // R7

  AST_SLIP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slip) > -W) && (int'(slip) < W)); // R7

  AST_SURPLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    surplus_evt |=> (slip == '0)); // R7

  AST_DEFICIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    deficit_evt |=> (slip == '0)); // R8

endmodule

bind bitslip_realign bsr_checker #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .ovf_err     (ovf_err),
  .unf_err     (unf_err),
  .surplus_evt (surplus_evt),
  .deficit_evt (deficit_evt),
  .slip        (slip_now),
  .fifo_level  (fifo_level)
);

// File: tb/tb_bitslip_realign.sv
`timescale 1ns/1ps
module tb_bitslip_realign;

  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W:0]   in_bits = '0;
  logic [1:0]   in_code = 2'b00;
  logic [W-1:0] out_byte;
  logic         out_valid, ovf_err, unf_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit tainted = 1'b0;
  bit mq[$];

  always #4 clk = ~clk;

  bitslip_realign #(.BYTE_W(W), .FIFO_DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .in_code(in_code), .out_byte(out_byte), .out_valid(out_valid),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && ovf_err == 1'b0 && unf_err == 1'b0, "R1",
        "flags in reset", {out_valid, ovf_err, unf_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mq.delete();
    for (int i = 0; i < W; i++) mq.push_back(1'b0);
    tainted = 1'b0;
  endtask

  task automatic send(input logic [1:0] code, input logic [W:0] bits,
                      input string tag);
    bit         exp_v, exp_o;
    logic [W-1:0] exp_b;
    @(negedge clk);
    in_valid = 1'b1; in_code = code; in_bits = bits;
    if (code == 2'b01)      for (int i = 1; i < W; i++)  mq.push_back(bits[i]);
    else if (code == 2'b10) for (int i = 0; i <= W; i++) mq.push_back(bits[i]);
    else                    for (int i = 0; i < W; i++)  mq.push_back(bits[i]);
    exp_b = '0;
    exp_v = (mq.size() > W);
    if (exp_v) for (int i = 0; i < W; i++) exp_b[i] = mq.pop_front();
    exp_o = exp_v && (mq.size() > 8 * D + 2 * W - 1);
    @(posedge clk);
    #1;
    chk(out_valid == exp_v, tag, "out_valid", out_valid, exp_v);
    chk(unf_err == !exp_v, tag, "unf_err", unf_err, !exp_v);
    chk(ovf_err == exp_o, tag, "ovf_err", ovf_err, exp_o);
    if (exp_v && !tainted) chk(out_byte == exp_b, tag, "out_byte", out_byte, exp_b);
    if (exp_o) tainted = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0; in_bits = 9'h1FF; in_code = 2'b10;
    @(posedge clk);
    #1;
    chk(!out_valid && !ovf_err && !unf_err, tag, "idle outputs",
        {out_valid, ovf_err, unf_err}, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk(out_byte == '0 && !out_valid, "R1", "after reset", out_byte, 0);
  endtask

  task automatic t_nominal();
    do_reset();
    send(2'b00, 9'h1A5, "R2");
    send(2'b00, 9'h13C, "R2");
    send(2'b00, 9'h0F0, "R2");
    send(2'b11, 9'h1C3, "R5");
    send(2'b11, 9'h15A, "R5");
    send(2'b00, 9'h1FF, "R5");
    send(2'b00, 9'h001, "R2");
  endtask

  task automatic t_idle();
    do_reset();
    send(2'b10, 9'h1B7, "R4");
    send(2'b00, 9'h066, "R6");
    idle("R6");
    idle("R6");
    send(2'b00, 9'h099, "R6");
    send(2'b01, 9'h0E1, "R6");
    idle("R6");
    send(2'b00, 9'h12D, "R6");
    send(2'b00, 9'h000, "R6");
  endtask

  task automatic t_short();
    do_reset();
    send(2'b00, 9'h0AA, "R3");
    send(2'b01, 9'h0F1, "R3");
    send(2'b00, 9'h055, "R3");
    send(2'b01, 9'h10E, "R3");
    send(2'b10, 9'h1E3, "R4");
    send(2'b00, 9'h0C7, "R3");
    send(2'b00, 9'h038, "R3");
  endtask

  task automatic t_bubble();
    do_reset();
    for (int k = 0; k < 8; k++) send(2'b01, 9'($urandom()), "R8");
    for (int k = 0; k < 4; k++) send(2'b00, 9'($urandom()), "R8");
  endtask

  task automatic t_surplus();
    do_reset();
    for (int k = 0; k < 8; k++)  send(2'b10, 9'($urandom()), "R7");
    for (int k = 0; k < 3; k++)  send(2'b00, 9'($urandom()), "R7");
    for (int k = 0; k < 8; k++)  send(2'b01, 9'($urandom()), "R9");
    for (int k = 0; k < 3; k++)  send(2'b00, 9'($urandom()), "R9");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 8 * D + 7; k++) send(2'b10, 9'($urandom()), "R7");
    send(2'b10, 9'h1C9, "R10");
    chk(tainted == 1'b1, "R10", "overflow reached", tainted, 1);
  endtask

  initial begin
    t_reset_state();
    t_nominal();
    t_idle();
    t_short();
    t_bubble();
    t_surplus();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule